// File: doc/BRIEF.md
# Shortened Burst Symbol Generator

This block produces, one di-bit at a time, the 162-symbol shortened uplink burst that a terminal sends so that the receiving station can measure timing alignment. A start pulse loads an assigned 14-symbol sync word and an assigned 6-symbol coded color code. From then on, each symbol-enable strobe moves the block to the next symbol. For every symbol the block presents a 2-bit value, a field tag and a transmit-active flag. Modulation and ramp shaping are done further down the transmit path. This block only marks the ramp symbols with a tag.

Six copies of the sync word are separated by color-code fields and by all-zero spacers. The spacers grow in length from one gap to the next. As a result, the distance between the starts of any two sync words is different for every pair. A receiver that detects any two sync words can therefore work out where they sit in the burst.

The controller is a state machine with these states: `ST_IDLE`, `ST_LEAD_GUARD`, `ST_LEAD_RAMP`, `ST_SYNC`, `ST_CODE`, `ST_SPACER`, `ST_TAIL_RAMP` and `ST_TAIL_GUARD`. It has these transitions:
- IDLE→LEAD_GUARD on start.
- LEAD_GUARD→LEAD_RAMP→SYNC at the end of each field.
- SYNC→CODE when more sync words follow, and SYNC→TAIL_RAMP after the sixth sync word.
- CODE→SYNC after the first color code, and CODE→SPACER after every later color code.
- SPACER→SYNC at the end of the spacer.
- TAIL_RAMP→TAIL_GUARD, then TAIL_GUARD→IDLE after the last symbol, which also raises done.

Top module: `short_burst_gen`

## Requirements
- R1: While idle, a start pulse latches `sync_word` and `color_code`, raises `busy` and presents symbol 0. While busy, start pulses and changes on the word inputs have no effect on the burst in progress.
- R2: The fields follow each other in this order: 3 leading guard, 3 ramp, then S D S D V S D W S D X S D Y S, then 22 trailing symbols whose first 3 are ramp. S is 14 symbols, D is 6 symbols, and the total is 162. The sync words start at symbols 6, 26, 48, 72, 98 and 126.
- R3: The spacer fields V, W, X and Y last 2, 4, 6 and 8 symbols, and every spacer symbol is 00.
- R4: Symbol k of a sync field is `sync_word[27-2k:26-2k]`, and symbol k of a code field is `color_code[11-2k:10-2k]`, so the first bit sent sits in the MSB of the di-bit. Guard and ramp symbols are 00.
- R5: `tx_on` is 0 while idle, during the leading guard and during the trailing symbols after the tail ramp. It is 1 in every other symbol.
- R6: `tag_out` uses this encoding: 0 for guard, 1 for ramp, 2 for sync, 3 for color code and 4 for spacer. It reads 0 while idle.
- R7: The burst moves forward by one symbol only when `sym_en` is high while busy. Without the strobe, all outputs hold. A strobe while idle has no effect.
- R8: The clock edge that accepts symbol 161 drops `busy` and raises `done` for exactly one cycle.
- R9: The distance between the starts of any two sync words is different for each pair.
- R10: After reset, `busy`, `done` and `tx_on` are 0, `tag_out` is 0 and `sym_out` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a burst (only acted on while idle) |
| sym_en | input | 1 | Accept the current symbol and move to the next |
| sync_word | input | 28 | Assigned sync word, first di-bit in the MSBs |
| color_code | input | 12 | Assigned coded color code, first di-bit in the MSBs |
| sym_out | output | 2 | Current di-bit |
| tag_out | output | 3 | Field tag of the current symbol |
| tx_on | output | 1 | Transmitter active for the current symbol |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse after the last symbol |

## Verification
A burst with distinct, asymmetric sync and code words shows whether di-bits are taken MSB-first and whether the sync and code sources are kept apart. An all-ones burst makes every zero spacer and guard symbol stand out against its neighbours. A burst with idle cycles between strobes separates stepping on the strobe from stepping on the clock. Other runs give a start pulse with changed words in the middle of a burst, strobes while idle, and back-to-back bursts; these separate proper latching and idle handling from leaks. The sync start positions seen in each burst are checked for the expected values and for pairwise-unique distances.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

    typedef enum logic [2:0] {
        TAG_GUARD  = 3'd0,
        TAG_RAMP   = 3'd1,
        TAG_SYNC   = 3'd2,
        TAG_CODE   = 3'd3,
        TAG_SPACER = 3'd4
    } tag_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD_GUARD,
        ST_LEAD_RAMP,
        ST_SYNC,
        ST_CODE,
        ST_SPACER,
        ST_TAIL_RAMP,
        ST_TAIL_GUARD
    } state_e;

endpackage

// File: rtl/sbg_seq.sv
module sbg_seq
    import sbg_pkg::*;
#(
    parameter int LEAD_GUARD = 3,
    parameter int RAMP_LEN   = 3,
    parameter int SYNC_LEN   = 14,
    parameter int CODE_LEN   = 6,
    parameter int SPC_STEP   = 2,
    parameter int NSYNC      = 6,
    parameter int TAIL_LEN   = 22,
    parameter int CW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          sym_en,
    output state_e        state,
    output logic [CW-1:0] cnt,
    output tag_e          tag,
    output logic          tx_on,
    output logic          busy,
    output logic          done,
    output logic          load
);

    localparam int GW = (NSYNC > 1) ? $clog2(NSYNC) : 1;

    state_e        nxt_state;
    logic [CW-1:0] nxt_cnt;
    logic [GW-1:0] grp, nxt_grp;
    logic [CW-1:0] field_len;
    logic          last;

    // length of the field the current state stands for
    always_comb begin
        unique case (state)
            ST_IDLE:       field_len = CW'(1);
            ST_LEAD_GUARD: field_len = CW'(LEAD_GUARD);
            ST_LEAD_RAMP:  field_len = CW'(RAMP_LEN);
            ST_SYNC:       field_len = CW'(SYNC_LEN);
            ST_CODE:       field_len = CW'(CODE_LEN);
            ST_SPACER:     field_len = CW'(SPC_STEP * int'(grp));
            ST_TAIL_RAMP:  field_len = CW'(RAMP_LEN);
            ST_TAIL_GUARD: field_len = CW'(TAIL_LEN - RAMP_LEN);
        endcase
    end

    assign last = (cnt == field_len - CW'(1));
    assign busy = (state != ST_IDLE);
    assign load = start && (state == ST_IDLE);

    // next-state logic
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_grp   = grp;
        if (state == ST_IDLE) begin
            if (start) begin
                nxt_state = ST_LEAD_GUARD;
                nxt_cnt   = '0;
                nxt_grp   = '0;
            end
        end else if (sym_en) begin
            if (!last) begin
                nxt_cnt = cnt + CW'(1);
            end else begin
                nxt_cnt = '0;
                unique case (state)
                    ST_LEAD_GUARD: nxt_state = ST_LEAD_RAMP;
                    ST_LEAD_RAMP:  nxt_state = ST_SYNC;
                    ST_SYNC: begin
                        if (grp == GW'(NSYNC - 1)) nxt_state = ST_TAIL_RAMP;
                        else                       nxt_state = ST_CODE;
                    end
                    ST_CODE: begin
                        if (grp == '0) begin
                            nxt_state = ST_SYNC;
                            nxt_grp   = grp + GW'(1);
                        end else begin
                            nxt_state = ST_SPACER;
                        end
                    end
                    ST_SPACER: begin
                        nxt_state = ST_SYNC;
                        nxt_grp   = grp + GW'(1);
                    end
                    ST_TAIL_RAMP:  nxt_state = ST_TAIL_GUARD;
                    ST_TAIL_GUARD: nxt_state = ST_IDLE;
                    ST_IDLE:       nxt_state = ST_IDLE;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            grp   <= '0;
            done  <= 1'b0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
            grp   <= nxt_grp;
            done  <= (state == ST_TAIL_GUARD) && sym_en && last;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_IDLE:       begin tag = TAG_GUARD;  tx_on = 1'b0; end
            ST_LEAD_GUARD: begin tag = TAG_GUARD;  tx_on = 1'b0; end
            ST_LEAD_RAMP:  begin tag = TAG_RAMP;   tx_on = 1'b1; end
            ST_SYNC:       begin tag = TAG_SYNC;   tx_on = 1'b1; end
            ST_CODE:       begin tag = TAG_CODE;   tx_on = 1'b1; end
            ST_SPACER:     begin tag = TAG_SPACER; tx_on = 1'b1; end
            ST_TAIL_RAMP:  begin tag = TAG_RAMP;   tx_on = 1'b1; end
            ST_TAIL_GUARD: begin tag = TAG_GUARD;  tx_on = 1'b0; end
        endcase
    end

endmodule

// File: rtl/sbg_symsel.sv
module sbg_symsel
    import sbg_pkg::*;
#(
    parameter int SYNC_LEN = 14,
    parameter int CODE_LEN = 6,
    parameter int CW       = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [2*SYNC_LEN-1:0] sync_word,
    input  logic [2*CODE_LEN-1:0] color_code,
    input  state_e                state,
    input  logic [CW-1:0]         cnt,
    output logic [1:0]            sym_out
);

    localparam int SW = 2 * SYNC_LEN;
    localparam int KW = 2 * CODE_LEN;

    logic [SW-1:0] sync_q, sync_sh;
    logic [KW-1:0] code_q, code_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            code_q <= '0;
        end else if (load) begin
            sync_q <= sync_word;
            code_q <= color_code;
        end
    end

    // first transmitted di-bit lives in the MSBs
    always_comb begin
        sync_sh = sync_q << (2 * cnt);
        code_sh = code_q << (2 * cnt);
        if (state == ST_SYNC)      sym_out = sync_sh[SW-1 -: 2];
        else if (state == ST_CODE) sym_out = code_sh[KW-1 -: 2];
        else                       sym_out = 2'b00;
    end

endmodule

// File: rtl/short_burst_gen.sv
module short_burst_gen
    import sbg_pkg::*;
#(
    parameter int LEAD_GUARD = 3,
    parameter int RAMP_LEN   = 3,
    parameter int SYNC_LEN   = 14,
    parameter int CODE_LEN   = 6,
    parameter int SPC_STEP   = 2,
    parameter int NSYNC      = 6,
    parameter int TAIL_LEN   = 22
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  sym_en,
    input  logic [2*SYNC_LEN-1:0] sync_word,
    input  logic [2*CODE_LEN-1:0] color_code,
    output logic [1:0]            sym_out,
    output logic [2:0]            tag_out,
    output logic                  tx_on,
    output logic                  busy,
    output logic                  done
);

    localparam int SLOT_LEN = LEAD_GUARD + RAMP_LEN + NSYNC * SYNC_LEN
                            + (NSYNC - 1) * CODE_LEN
                            + SPC_STEP * (NSYNC - 1) * (NSYNC - 2) / 2
                            + TAIL_LEN;
    localparam int CW = $clog2(SLOT_LEN + 1);

    state_e        state;
    logic [CW-1:0] cnt;
    tag_e          tag;
    logic          load;

    sbg_seq #(
        .LEAD_GUARD(LEAD_GUARD), .RAMP_LEN(RAMP_LEN), .SYNC_LEN(SYNC_LEN),
        .CODE_LEN(CODE_LEN), .SPC_STEP(SPC_STEP), .NSYNC(NSYNC),
        .TAIL_LEN(TAIL_LEN), .CW(CW)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .sym_en(sym_en),
        .state(state), .cnt(cnt), .tag(tag), .tx_on(tx_on),
        .busy(busy), .done(done), .load(load)
    );

    sbg_symsel #(
        .SYNC_LEN(SYNC_LEN), .CODE_LEN(CODE_LEN), .CW(CW)
    ) sel_i (
        .clk(clk), .rst_n(rst_n), .load(load),
        .sync_word(sync_word), .color_code(color_code),
        .state(state), .cnt(cnt), .sym_out(sym_out)
    );

    assign tag_out = tag;

endmodule

// File: rtl/sbg_chk.sv
module sbg_chk #(
    parameter int SLOT_LEN = 162
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       sym_en,
    input logic [1:0] sym_out,
    input logic [2:0] tag_out,
    input logic       tx_on,
    input logic       busy,
    input logic       done
);

    logic [15:0] n_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 n_acc <= '0;
        else if (start && !busy)    n_acc <= '0;
        else if (busy && sym_en)    n_acc <= n_acc + 16'd1;
    end

    p_start_enters_guard_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && tag_out == 3'd0 && !tx_on));

    p_slot_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (n_acc == 16'(SLOT_LEN)));

    p_spacer_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_out == 3'd4) |-> (sym_out == 2'b00));

    p_guard_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_out == 3'd0) |-> (!tx_on && sym_out == 2'b00));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tx_on && tag_out == 3'd0));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sym_en) |=> ($stable(sym_out) && $stable(tag_out) && busy));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind short_burst_gen sbg_chk #(.SLOT_LEN(SLOT_LEN)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sym_en(sym_en),
    .sym_out(sym_out), .tag_out(tag_out), .tx_on(tx_on),
    .busy(busy), .done(done)
);

// File: tb/short_burst_gen_tb_top.sv
`timescale 1ns/1ps
module short_burst_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sym_en = 1'b0;
    logic [27:0] sync_word = '0;
    logic [11:0] color_code = '0;
    logic [1:0]  sym_out;
    logic [2:0]  tag_out;
    logic        tx_on;
    logic        busy;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    short_burst_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .sym_en(sym_en),
        .sync_word(sync_word), .color_code(color_code),
        .sym_out(sym_out), .tag_out(tag_out), .tx_on(tx_on),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected symbol from the requirement text (R2 R3 R4 R5 R6)
    task automatic expect_at(input int i, input logic [27:0] sw, input logic [11:0] cc,
                             output int et, output int es, output int ex);
        int p;
        bit found;
        et = 0; es = 0; ex = 0;
        if (i < 3) begin
            et = 0; ex = 0;
        end else if (i < 6) begin
            et = 1; ex = 1;
        end else if (i >= 140) begin
            if (i < 143) begin et = 1; ex = 1; end
            else begin et = 0; ex = 0; end
        end else begin
            p = i - 6;
            found = 0;
            ex = 1;
            for (int g = 0; g < 6 && !found; g++) begin
                if (p < 14) begin
                    et = 2; es = int'(sw[27 - 2*p -: 2]); found = 1;
                end else begin
                    p -= 14;
                    if (p < 6) begin
                        et = 3; es = int'(cc[11 - 2*p -: 2]); found = 1;
                    end else begin
                        p -= 6;
                        if (p < 2*g) begin
                            et = 4; es = 0; found = 1;
                        end else begin
                            p -= 2*g;
                        end
                    end
                end
            end
        end
    endtask

    task automatic cmp_sym(input int i, input logic [27:0] sw, input logic [11:0] cc);
        int et, es, ex;
        expect_at(i, sw, cc, et, es, ex);
        chk(int'(tag_out) == et, (et == 4) ? "R3 R6 tag" : "R2 R6 tag", int'(tag_out), et);
        chk(int'(sym_out) == es, (et == 4) ? "R3 spacer sym" : "R4 sym", int'(sym_out), es);
        chk(int'(tx_on) == ex, "R5 tx_on", int'(tx_on), ex);
        chk(busy === 1'b1 && done === 1'b0, "R7 busy during burst", int'(busy), 1);
    endtask

    task automatic run_burst(input logic [27:0] sw, input logic [11:0] cc,
                             input int gap, input bit poke);
        int starts[$];
        int prev_tag;
        int exp_starts[6] = '{6, 26, 48, 72, 98, 126};
        int dup;
        sync_word  = sw;
        color_code = cc;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        chk(busy === 1'b1, "R1 busy after start", int'(busy), 1);
        prev_tag = 0;
        for (int i = 0; i < 162; i++) begin
            for (int w = 0; w < gap; w++) begin
                cmp_sym(i, sw, cc); // R7 hold without strobe
                @(negedge clk);
            end
            cmp_sym(i, sw, cc);
            if (tag_out == 3'd2 && prev_tag != 2) starts.push_back(i);
            prev_tag = int'(tag_out);
            if (poke && i == 50) begin
                start      = 1'b1; // R1 ignored while busy
                sync_word  = ~sw;
                color_code = ~cc;
            end
            sym_en = 1'b1;
            @(negedge clk);
            sym_en = 1'b0;
            start  = 1'b0;
        end
        chk(done === 1'b1, "R8 done after last", int'(done), 1);
        chk(busy === 1'b0, "R8 busy drops", int'(busy), 0);
        @(negedge clk);
        chk(done === 1'b0, "R8 done one cycle", int'(done), 0);
        chk(tx_on === 1'b0 && tag_out == 3'd0, "R5 idle after burst", int'(tx_on), 0);
        chk(starts.size() == 6, "R2 sync count", starts.size(), 6);
        if (starts.size() == 6) begin
            for (int k = 0; k < 6; k++)
                chk(starts[k] == exp_starts[k], "R2 sync start", starts[k], exp_starts[k]);
            dup = 0;
            for (int a = 0; a < 6; a++)
                for (int b = a + 1; b < 6; b++)
                    for (int c = 0; c < 6; c++)
                        for (int d = c + 1; d < 6; d++)
                            if ((a != c || b != d) &&
                                (starts[b] - starts[a]) == (starts[d] - starts[c]))
                                dup++;
            chk(dup == 0, "R9 unique sync distances", dup, 0);
        end
        sync_word  = sw;
        color_code = cc;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R10 reset busy/done", int'(busy), 0);
        chk(tx_on === 1'b0, "R10 reset tx_on", int'(tx_on), 0);
        chk(tag_out === 3'd0 && sym_out === 2'b00, "R10 reset tag/sym",
            int'(tag_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R10 idle after release", int'(busy), 0);
    endtask

    task automatic t_idle_strobe;
        sym_en = 1'b1;
        repeat (5) @(negedge clk);
        sym_en = 1'b0;
        chk(busy === 1'b0, "R7 strobe while idle", int'(busy), 0);
        chk(tag_out === 3'd0 && sym_out === 2'b00 && tx_on === 1'b0,
            "R7 idle outputs", int'(tag_out), 0);
    endtask

    task automatic t_distinct;  run_burst(28'h1B2_C3D4, 12'h9E1, 0, 0); endtask
    task automatic t_all_ones;  run_burst(28'hFFF_FFFF, 12'hFFF, 0, 0); endtask
    task automatic t_gaps;      run_burst(28'h5A3_C96F, 12'h3C5, 2, 0); endtask
    task automatic t_restart;   run_burst(28'h0F0_F0F1, 12'h6A9, 1, 1); endtask
    task automatic t_back2back;
        run_burst(28'h8421_0F3, 12'h1E7, 0, 0);
        run_burst(28'h7BDE_F0C, 12'hE18, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle_strobe();
        t_distinct();
        t_all_ones();
        t_gaps();
        t_restart();
        t_back2back();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule